// File: doc/BRIEF.md
# Packed Halfword Index Extremum Tracker

This block performs one step of a running search for the largest or smallest value in a stream of 16-bit samples, and tracks where that value was found. Each step takes one 32-bit data word that carries two samples, a low halfword and a high halfword. It also takes a 64-bit accumulator word and returns that word updated. The accumulator holds three fields. A running sample index sits in bits 15:0. The index of the best sample found so far sits in bits 31:16. The best value itself sits in bits 47:32. Software or a surrounding datapath seeds the accumulator and feeds the result back in as the next step's accumulator.

Two select inputs choose the behaviour. One picks maximum search or minimum search. The other picks whether samples and the stored extreme are compared as two's-complement or as unsigned numbers. When the two halves tie, the low halfword is preferred. A new sample must be strictly better than the stored extreme to replace it. The running index always advances by two.

The control is a two-state machine. In `ST_IDLE` no result is presented. In `ST_RESULT` the registered accumulator is presented with `out_valid` high. From either state the transition `take` (with `in_valid` high) leads to `ST_RESULT`, and the transition `drain` (with `in_valid` low) leads to `ST_IDLE`. A synchronous reset forces `ST_IDLE` and clears the result.

Top module: `idx_extremum_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc_out` becomes all zeros and `out_valid` becomes 0 after that edge.
- R2: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low otherwise. When `in_valid` is low, `acc_out` keeps its previous value regardless of `acc_in` and `data_in`.
- R3: After a valid step, `acc_out[15:0]` equals `acc_in[15:0] + 2` modulo 2^16.
- R4: In max mode (`find_min`=0), the low halfword `data_in[15:0]` wins when it is greater than or equal to `data_in[31:16]` and strictly greater than `acc_in[47:32]`. The result then has `acc_out[47:32]` = the low halfword and `acc_out[31:16]` = `acc_in[15:0]`.
- R5: In max mode, when the low halfword does not win, the high halfword wins when it is strictly greater than the low halfword and strictly greater than `acc_in[47:32]`. The result then has `acc_out[47:32]` = the high halfword and `acc_out[31:16]` = `acc_in[15:0] + 1` modulo 2^16.
- R6: When neither halfword wins (including a sample equal to the stored extreme), `acc_out[47:16]` equals `acc_in[47:16]`.
- R7: `acc_out[63:48]` is always zero, and `acc_in[63:48]` has no effect on the result.
- R8: In min mode (`find_min`=1), the rules of R4 and R5 apply with the comparisons reversed. The low half needs to be less than or equal to the high half and strictly less than the stored extreme. The high half needs to be strictly less than the low half and strictly less than the stored extreme.
- R9: With `is_signed`=1, both halfwords and the stored extreme are compared as 16-bit two's-complement values. With `is_signed`=0 they are compared as unsigned values. For example, 0x8000 is below 0x7FFF when signed and above it when unsigned.
- R10: When the running index is 0xFFFF, a high-halfword win records index 0x0000 and the new running index is 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts one step at this edge |
| acc_in | input | 64 | Current accumulator: running index [15:0], extreme index [31:16], extreme value [47:32] |
| data_in | input | 32 | Two packed samples: low [15:0], high [31:16] |
| find_min | input | 1 | 1 = minimum search, 0 = maximum search |
| is_signed | input | 1 | 1 = two's-complement compare, 0 = unsigned compare |
| out_valid | output | 1 | Registered result is valid |
| acc_out | output | 64 | Updated accumulator, registered |

## Verification
The bench targets several corner cases, each of which exposes a specific kind of fault:

- **Equal halfwords.** A design that breaks the tie the wrong way would record the high half and an index that is off by one.
- **Samples exactly equal to the stored extreme.** A design that used a non-strict compare against the extreme would rewrite the index field even though the value did not change.
- **The 0x8000/0x7FFF pair in both compare modes.** A wrong sign extension flips the winner, so the extreme field would hold the other sample.
- **Running index at 0xFFFE and 0xFFFF.** These catch increments carried into bit 16 or computed at the wrong width.
- **Garbage in the upper accumulator bits and idle cycles with changing inputs.** These show whether ignored bits leak into the result and whether the output register updates without a valid step.

// File: rtl/hx_pkg.sv
package hx_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } trk_state_e;

endpackage

// File: rtl/hx_cmp.sv
// Halfword comparator: one operand against another, in the sense chosen by
// the search direction, with a selectable signed or unsigned interpretation.
module hx_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         is_signed,
    input  logic         find_min,
    output logic         beats,       // lhs strictly better than rhs
    output logic         beats_or_eq  // lhs better than or equal to rhs
);
    logic signed [W:0] lhs_x;
    logic signed [W:0] rhs_x;
    logic              gt;
    logic              lt;

    always_comb begin
        lhs_x = {is_signed & lhs[W-1], lhs};
        rhs_x = {is_signed & rhs[W-1], rhs};
        gt    = lhs_x > rhs_x;
        lt    = lhs_x < rhs_x;
        if (find_min) begin
            beats       = lt;
            beats_or_eq = !gt;
        end else begin
            beats       = gt;
            beats_or_eq = !lt;
        end
    end
endmodule

// File: rtl/hx_pack.sv
// Field update: advances the running index and installs the winning sample.
module hx_pack #(
    parameter int W = 16
) (
    input  logic [3*W-1:0] acc_fields,
    input  logic [2*W-1:0] samples,
    input  logic           lo_win,
    input  logic           hi_win,
    output logic [4*W-1:0] acc_next
);
    logic [W-1:0] run_idx;

    always_comb begin
        run_idx  = acc_fields[W-1:0];
        acc_next = '0;
        acc_next[W-1:0] = run_idx + W'(2);
        if (lo_win) begin
            acc_next[2*W-1:W]   = run_idx;
            acc_next[3*W-1:2*W] = samples[W-1:0];
        end else if (hi_win) begin
            acc_next[2*W-1:W]   = run_idx + W'(1);
            acc_next[3*W-1:2*W] = samples[2*W-1:W];
        end else begin
            acc_next[3*W-1:W]   = acc_fields[3*W-1:W];
        end
    end
endmodule

// File: rtl/idx_extremum_tracker.sv
module idx_extremum_tracker #(
    parameter int HALF_W = 16,
    localparam int ACC_W = 4 * HALF_W,
    localparam int DAT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [DAT_W-1:0] data_in,
    input  logic             find_min,
    input  logic             is_signed,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc_out
);
    import hx_pkg::*;

    trk_state_e       state_q;
    trk_state_e       state_d;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    logic [HALF_W-1:0] lo_s;
    logic [HALF_W-1:0] hi_s;
    logic [HALF_W-1:0] ext_v;
    logic lo_vs_hi_strict, lo_vs_hi_eq;
    logic lo_vs_ext_strict, lo_vs_ext_eq;
    logic hi_vs_ext_strict, hi_vs_ext_eq;
    logic lo_win, hi_win;

    assign lo_s  = data_in[HALF_W-1:0];
    assign hi_s  = data_in[DAT_W-1:HALF_W];
    assign ext_v = acc_in[3*HALF_W-1:2*HALF_W];

    hx_cmp #(.W(HALF_W)) u_lo_hi (
        .lhs(lo_s), .rhs(hi_s), .is_signed(is_signed), .find_min(find_min),
        .beats(lo_vs_hi_strict), .beats_or_eq(lo_vs_hi_eq)
    );

    hx_cmp #(.W(HALF_W)) u_lo_ext (
        .lhs(lo_s), .rhs(ext_v), .is_signed(is_signed), .find_min(find_min),
        .beats(lo_vs_ext_strict), .beats_or_eq(lo_vs_ext_eq)
    );

    hx_cmp #(.W(HALF_W)) u_hi_ext (
        .lhs(hi_s), .rhs(ext_v), .is_signed(is_signed), .find_min(find_min),
        .beats(hi_vs_ext_strict), .beats_or_eq(hi_vs_ext_eq)
    );

    // Low half takes ties against the high half; the high half must beat the
    // low half strictly, which is the complement of the low half's tie rule.
    assign lo_win = lo_vs_hi_eq & lo_vs_ext_strict;
    assign hi_win = !lo_vs_hi_eq & hi_vs_ext_strict;

    hx_pack #(.W(HALF_W)) u_pack (
        .acc_fields(acc_in[3*HALF_W-1:0]),
        .samples   (data_in),
        .lo_win    (lo_win),
        .hi_win    (hi_win),
        .acc_next  (acc_d)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;   // take / drain
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;   // take / drain
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (in_valid) acc_q <= acc_d;
    end

    assign out_valid = (state_q == ST_RESULT);
    assign acc_out   = acc_q;

endmodule

// File: rtl/idx_extremum_chk.sv
module idx_extremum_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [4*HALF_W-1:0] acc_in,
    input logic                out_valid,
    input logic [4*HALF_W-1:0] acc_out
);
    localparam int W = HALF_W;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && acc_out == '0));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(acc_out)));

    // R3
    run_index_step_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> acc_out[W-1:0] == W'($past(acc_in[W-1:0]) + W'(2)));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        acc_out[4*W-1:3*W] == '0);

    // R6
    fields_origin_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((acc_out[2*W-1:W] == $past(acc_in[W-1:0]))
                   || (acc_out[2*W-1:W] == W'($past(acc_in[W-1:0]) + W'(1)))
                   || (acc_out[3*W-1:W] == $past(acc_in[3*W-1:W]))));
endmodule

bind idx_extremum_tracker idx_extremum_chk #(.HALF_W(HALF_W)) i_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out)
);

// File: tb/test_idx_extremum_tracker.sv
module test_idx_extremum_tracker;
    localparam int CLK_NS   = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] acc_in = '0;
    logic [31:0] data_in = '0;
    logic        find_min = 1'b0;
    logic        is_signed = 1'b0;
    logic        out_valid;
    logic [63:0] acc_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    idx_extremum_tracker i_idx_extremum_tracker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
        .data_in(data_in), .find_min(find_min), .is_signed(is_signed),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int as_num(logic [15:0] v, bit sg);
        if (sg) return int'($signed(v));
        return int'(v);
    endfunction

    // Behavioural reference of one step, written from the requirements.
    function automatic logic [63:0] model(logic [63:0] a, logic [31:0] d, bit mn, bit sg);
        int lo, hi, ex, run;
        bit low_takes, high_takes;
        logic [63:0] r;
        lo  = as_num(d[15:0], sg);
        hi  = as_num(d[31:16], sg);
        ex  = as_num(a[47:32], sg);
        run = int'(a[15:0]);
        if (mn) begin
            low_takes  = (lo <= hi) && (lo < ex);
            high_takes = (hi < lo) && (hi < ex);
        end else begin
            low_takes  = (lo >= hi) && (lo > ex);
            high_takes = (hi > lo) && (hi > ex);
        end
        r = '0;
        r[15:0] = 16'((run + 2) % 65536);
        if (low_takes) begin
            r[31:16] = 16'(run);
            r[47:32] = d[15:0];
        end else if (high_takes) begin
            r[31:16] = 16'((run + 1) % 65536);
            r[47:32] = d[31:16];
        end else begin
            r[47:16] = a[47:16];
        end
        return r;
    endfunction

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One valid step: drive after a falling edge, sample at the next falling edge.
    task automatic step(logic [63:0] a, logic [31:0] d, bit mn, bit sg, string req);
        logic [63:0] exp;
        exp = model(a, d, mn, sg);
        in_valid  = 1'b1;
        acc_in    = a;
        data_in   = d;
        find_min  = mn;
        is_signed = sg;
        @(negedge clk);
        check64("R2", {63'd0, out_valid}, 64'd1);
        check64(req, acc_out, exp);
        check64("R3", {48'd0, acc_out[15:0]}, {48'd0, 16'(a[15:0] + 16'd2)});
        check64("R7", {48'd0, acc_out[63:48]}, 64'd0);
    endtask

    task automatic idle_step(logic [63:0] a, logic [31:0] d);
        logic [63:0] held;
        held     = acc_out;
        in_valid = 1'b0;
        acc_in   = a;
        data_in  = d;
        @(negedge clk);
        check64("R2", {63'd0, out_valid}, 64'd0);
        check64("R2", acc_out, held);
    endtask

    function automatic logic [63:0] mk(logic [15:0] ext, logic [15:0] idx, logic [15:0] run);
        return {16'h0000, ext, idx, run};
    endfunction

    initial begin
        #(CLK_NS * WATCHDOG);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check64("R1", {63'd0, out_valid}, 64'd0);
        check64("R1", acc_out, 64'd0);
        rst = 1'b0;

        // R4 max, low clearly wins
        step(mk(16'h0005, 16'h0003, 16'h0010), {16'h0002, 16'h0009}, 0, 1, "R4");
        // R4 tie between halves goes to low
        step(mk(16'h0005, 16'h0003, 16'h0020), {16'h0007, 16'h0007}, 0, 1, "R4");
        // R5 high wins
        step(mk(16'h0005, 16'h0003, 16'h0030), {16'h0020, 16'h0003}, 0, 0, "R5");
        // R6 equal to stored extreme: no update
        step(mk(16'h0005, 16'h0003, 16'h0040), {16'h0005, 16'h0005}, 0, 1, "R6");
        step(mk(16'h0005, 16'h0003, 16'h0041), {16'h0005, 16'h0005}, 1, 0, "R6");
        // R9 signed: 0x7FFF beats 0x8000
        step(mk(16'h8000, 16'h0001, 16'h0050), {16'h8000, 16'h7FFF}, 0, 1, "R9");
        // R9 unsigned: 0x8000 beats 0x7FFF
        step(mk(16'h0000, 16'h0001, 16'h0060), {16'h8000, 16'h7FFF}, 0, 0, "R9");
        // R9 signed min: 0x8000 is the smallest
        step(mk(16'h0000, 16'h0001, 16'h0070), {16'h8000, 16'h7FFF}, 1, 1, "R9");
        // R8 min, tie goes to low
        step(mk(16'h0009, 16'h0001, 16'h0080), {16'h0004, 16'h0004}, 1, 0, "R8");
        // R8 min, high wins
        step(mk(16'h0009, 16'h0001, 16'h0090), {16'h0002, 16'h0006}, 1, 0, "R8");
        // R10 wraparound on high-half index
        step(mk(16'h0000, 16'h0001, 16'hFFFF), {16'h0100, 16'h0010}, 0, 0, "R10");
        // R3 wraparound of running index with low win
        step(mk(16'h0000, 16'h0001, 16'hFFFE), {16'h0010, 16'h0100}, 0, 0, "R3");
        // R7 upper input bits ignored
        step(64'hABCD_0005_0003_0100 | 64'h0, {16'h0001, 16'h0009}, 0, 1, "R7");
        step(64'hFFFF_0005_0003_0102, {16'h0001, 16'h0002}, 0, 1, "R7");
        // R2 idle hold with changing inputs
        idle_step(64'h1234_5678_9ABC_DEF0, 32'hFFFF_0000);
        idle_step(64'h0, 32'h7FFF_8000);

        // Random steps with occasional idle cycles
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a;
            logic [31:0] d;
            a = {$urandom, $urandom};
            d = $urandom;
            if (i % 7 == 0) d[31:16] = d[15:0];
            if (i % 11 == 0) d[15:0] = a[47:32];
            if (i % 13 == 0) a[15:0] = 16'hFFFF;
            step(a, d, 1'($urandom), 1'($urandom), "R4");
            if (i % 17 == 0) idle_step({$urandom, $urandom}, $urandom);
        end

        // R1 reset after activity
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check64("R1", {63'd0, out_valid}, 64'd0);
        check64("R1", acc_out, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule